// File: doc/BRIEF.md
# Keyed Toeplitz Field Hasher

This block squeezes a 128-bit header field, typically an IPv6 source or destination address, into a 32-bit keyed Toeplitz hash. A lookup key can then carry the short hash instead of the full field. Each of two interfaces (receive and transmit) owns a set of three secret-key registers. Each interface also has two hash slots, and every slot holds a pair of 64-bit input masks and a 64-bit result-control word. The input is masked, hashed one bit per clock against a 159-bit key built from the three secret registers, and the result is shaped by an AND-mask followed by an OR-offset.

Requests enter on a valid/ready stream that carries the field, the interface and the slot. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. While a hash is in flight, `req_ready` stays low and `busy` is high. Results leave on a second valid/ready stream. Once `res_valid` rises, it and `res_hash` hold steady until the consumer raises `res_ready`, and only then does the block take a new request. The register port is a plain write strobe with a combinational read. Address bit 4 selects the interface, and the low four bits select a register inside that interface.

Top module: `toeplitz_field_hasher`

## Requirements
- R1: `req_data[127:96]` carries address word 0, the most significant word. Words 1, 2 and 3 follow toward bit 0. Data bit 127 is the first bit processed.
- R2: Before hashing, `req_data[127:64]` is ANDed with the slot's upper mask (offset 4+4·slot) and `req_data[63:0]` with its lower mask (offset 5+4·slot).
- R3: The 159-bit key is built from three registers. Bits 158:95 hold key register A (offset 0), bits 94:31 hold key register B (offset 1), and bits 30:0 hold the low 31 bits of the 32-bit key register C (offset 2).
- R4: The accumulator starts at zero. For each data bit, from bit 127 down to bit 0, a set bit XORs the current key bits 158:127 into it. After every bit the key shifts left by one, with a zero entering at the bottom.
- R5: The result is (accumulator AND control[63:32]) OR control[31:0], using the slot's control word at offset 6+4·slot.
- R6: Every interface has its own key registers, masks and control words. A write to one interface leaves the other interface's results unchanged.
- R7: After reset the registers read as follows. Key A reads 0xa9d5af4c9fbc76b1, key B reads 0xa9d5af4c9fbc87b4 and key C reads 0x5954c9e7. Every mask reads all ones, and every control word reads 0xffffffff00000000.
- R8: Offset 3 is a read-only capability word with only bit 62 set. Writes to it have no effect.
- R9: If a request is accepted at clock edge k, `res_valid` is high from edge k+128 on.
- R10: From acceptance until its result is taken, `req_ready` is low and `busy` is high. A request presented in that window is dropped and yields no result.
- R11: While `res_valid` is high and `res_ready` is low, `res_hash` does not change. The edge that completes the handshake returns the block to idle.
- R12: Keys, masks and control are captured when a request is accepted. Register writes made while that hash runs do not change its result.
- R13: Out of reset, `req_ready` is high and both `res_valid` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address: bit 4 selects the interface, bits 3:0 the offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Combinational read data for `reg_addr` |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (block idle) |
| req_if | input | 1 | Interface select for the request |
| req_slot | input | 1 | Hash slot select for the request |
| req_data | input | 128 | Field to hash |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result ready |
| res_hash | output | 32 | Shaped 32-bit hash |
| busy | output | 1 | Hash in flight or result waiting |

## Verification
A lone set bit at position 127 must return the top 32 bits of key A. A lone bit at position 0 must return key bits 31:0, which come from key B bit 0 and key C. These two cases pin the processing order and the key layout. All-zero data, and data whose only set bits fall under a cleared mask half, must return just the offset, which separates masking from hashing. Random fields, keys, masks and control words under a fixed seed are compared against a bench model. Directed runs cover a write to the other interface, a write to the active interface during a hash, a request made while busy, and a result held back by a low `res_ready`.

// File: rtl/fh_pkg.sv
package fh_pkg;
  localparam logic [63:0] KEY_A_RST = 64'ha9d5af4c9fbc76b1;
  localparam logic [63:0] KEY_B_RST = 64'ha9d5af4c9fbc87b4;
  localparam logic [63:0] KEY_C_RST = 64'h00000000_5954c9e7;
  localparam int CAP_BIT       = 62;
  localparam int OFS_KEY_A     = 0;
  localparam int OFS_KEY_B     = 1;
  localparam int OFS_KEY_C     = 2;
  localparam int OFS_CAP       = 3;
  localparam int OFS_SLOT_BASE = 4;
  localparam int SLOT_STRIDE   = 4;
  localparam int SLOT_MASK_HI  = 0;
  localparam int SLOT_MASK_LO  = 1;
  localparam int SLOT_CTL      = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD} core_state_e;
endpackage

// File: rtl/fh_cfg_regs.sv
module fh_cfg_regs #(
  parameter int NUM_IF   = 2,
  parameter int NUM_SLOT = 2,
  parameter int REG_W    = 64,
  parameter int RES_W    = 32,
  parameter int IF_W     = 1,
  parameter int SLOT_W   = 1,
  parameter int OFS_W    = 4,
  localparam int ADDR_W  = IF_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic [IF_W-1:0]   sel_if,
  input  logic [SLOT_W-1:0] sel_slot,
  output logic [REG_W-1:0]  sel_key_a,
  output logic [REG_W-1:0]  sel_key_b,
  output logic [RES_W-1:0]  sel_key_c,
  output logic [REG_W-1:0]  sel_mask_hi,
  output logic [REG_W-1:0]  sel_mask_lo,
  output logic [REG_W-1:0]  sel_ctl
);
  import fh_pkg::*;

  localparam logic [REG_W-1:0] CTL_RST = {{(REG_W-RES_W){1'b1}}, {RES_W{1'b0}}};

  logic [IF_W-1:0]  addr_if;
  logic [OFS_W-1:0] ofs;
  assign addr_if = addr[ADDR_W-1:OFS_W];
  assign ofs     = addr[OFS_W-1:0];

  logic [REG_W-1:0] key_a_arr [NUM_IF];
  logic [REG_W-1:0] key_b_arr [NUM_IF];
  logic [RES_W-1:0] key_c_arr [NUM_IF];
  logic [REG_W-1:0] mhi_arr   [NUM_IF][NUM_SLOT];
  logic [REG_W-1:0] mlo_arr   [NUM_IF][NUM_SLOT];
  logic [REG_W-1:0] ctl_arr   [NUM_IF][NUM_SLOT];

  for (genvar gi = 0; gi < NUM_IF; gi++) begin : g_if
    logic             if_wr;
    logic [REG_W-1:0] key_a_r, key_b_r;
    logic [RES_W-1:0] key_c_r;
    assign if_wr = wr_en && (int'(addr_if) == gi);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        key_a_r <= KEY_A_RST[REG_W-1:0];
        key_b_r <= KEY_B_RST[REG_W-1:0];
        key_c_r <= KEY_C_RST[RES_W-1:0];
      end else if (if_wr) begin
        if (ofs == OFS_W'(OFS_KEY_A)) key_a_r <= wdata;
        if (ofs == OFS_W'(OFS_KEY_B)) key_b_r <= wdata;
        if (ofs == OFS_W'(OFS_KEY_C)) key_c_r <= wdata[RES_W-1:0];
      end
    end
    assign key_a_arr[gi] = key_a_r;
    assign key_b_arr[gi] = key_b_r;
    assign key_c_arr[gi] = key_c_r;

    for (genvar gs = 0; gs < NUM_SLOT; gs++) begin : g_slot
      localparam int BASE = OFS_SLOT_BASE + gs * SLOT_STRIDE;
      logic [REG_W-1:0] mhi_r, mlo_r, ctl_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mhi_r <= '1;
          mlo_r <= '1;
          ctl_r <= CTL_RST;
        end else if (if_wr) begin
          if (ofs == OFS_W'(BASE + SLOT_MASK_HI)) mhi_r <= wdata;
          if (ofs == OFS_W'(BASE + SLOT_MASK_LO)) mlo_r <= wdata;
          if (ofs == OFS_W'(BASE + SLOT_CTL))     ctl_r <= wdata;
        end
      end
      assign mhi_arr[gi][gs] = mhi_r;
      assign mlo_arr[gi][gs] = mlo_r;
      assign ctl_arr[gi][gs] = ctl_r;
    end
  end

  // Read side: offsets inside the addressed interface
  always_comb begin
    rdata = '0;
    if (int'(addr_if) < NUM_IF) begin
      if (ofs == OFS_W'(OFS_KEY_A)) rdata = key_a_arr[addr_if];
      if (ofs == OFS_W'(OFS_KEY_B)) rdata = key_b_arr[addr_if];
      if (ofs == OFS_W'(OFS_KEY_C)) rdata = REG_W'(key_c_arr[addr_if]);
      if (ofs == OFS_W'(OFS_CAP))   rdata[CAP_BIT] = 1'b1;
      for (int s = 0; s < NUM_SLOT; s++) begin
        if (int'(ofs) == OFS_SLOT_BASE + s * SLOT_STRIDE + SLOT_MASK_HI) rdata = mhi_arr[addr_if][s];
        if (int'(ofs) == OFS_SLOT_BASE + s * SLOT_STRIDE + SLOT_MASK_LO) rdata = mlo_arr[addr_if][s];
        if (int'(ofs) == OFS_SLOT_BASE + s * SLOT_STRIDE + SLOT_CTL)     rdata = ctl_arr[addr_if][s];
      end
    end
  end

  // Request side: configuration of the interface and slot being asked for
  assign sel_key_a   = key_a_arr[sel_if];
  assign sel_key_b   = key_b_arr[sel_if];
  assign sel_key_c   = key_c_arr[sel_if];
  assign sel_mask_hi = mhi_arr[sel_if][sel_slot];
  assign sel_mask_lo = mlo_arr[sel_if][sel_slot];
  assign sel_ctl     = ctl_arr[sel_if][sel_slot];
endmodule

// File: rtl/fh_prep.sv
module fh_prep #(
  parameter int REG_W   = 64,
  parameter int RES_W   = 32,
  localparam int DATA_W = 2 * REG_W,
  localparam int KEY_W  = 2 * REG_W + RES_W - 1
) (
  input  logic [DATA_W-1:0] field,
  input  logic [REG_W-1:0]  mask_hi,
  input  logic [REG_W-1:0]  mask_lo,
  input  logic [REG_W-1:0]  key_a,
  input  logic [REG_W-1:0]  key_b,
  input  logic [RES_W-1:0]  key_c,
  output logic [DATA_W-1:0] masked,
  output logic [KEY_W-1:0]  key
);
  // Upper half of the field is matched against the upper mask word
  assign masked = {field[DATA_W-1:REG_W] & mask_hi, field[REG_W-1:0] & mask_lo};
  // Key C contributes only its low RES_W-1 bits at the bottom
  assign key    = {key_a, key_b, key_c[RES_W-2:0]};
endmodule

// File: rtl/fh_serial_core.sv
module fh_serial_core #(
  parameter int DATA_W = 128,
  parameter int KEY_W  = 159,
  parameter int RES_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DATA_W-1:0]    in_data,
  input  logic [KEY_W-1:0]     in_key,
  input  logic [2*RES_W-1:0]   in_ctl,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [RES_W-1:0]     out_hash,
  output logic                 busy
);
  import fh_pkg::*;

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  core_state_e       state_q;
  logic [DATA_W-1:0] data_q;
  logic [KEY_W-1:0]  key_q;
  logic [RES_W-1:0]  acc_q, acc_nxt, mask_q, off_q, res_q;
  logic [CNT_W-1:0]  cnt_q;

  always_comb begin
    acc_nxt = acc_q;
    if (data_q[DATA_W-1]) acc_nxt = acc_q ^ key_q[KEY_W-1 -: RES_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
      key_q   <= '0;
      acc_q   <= '0;
      mask_q  <= '0;
      off_q   <= '0;
      res_q   <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (in_valid) begin
            data_q  <= in_data;
            key_q   <= in_key;
            acc_q   <= '0;
            cnt_q   <= '0;
            mask_q  <= in_ctl[2*RES_W-1:RES_W];
            off_q   <= in_ctl[RES_W-1:0];
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          acc_q  <= acc_nxt;
          key_q  <= {key_q[KEY_W-2:0], 1'b0};
          data_q <= {data_q[DATA_W-2:0], 1'b0};
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            res_q   <= (acc_nxt & mask_q) | off_q;
            state_q <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (out_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_HOLD);
  assign out_hash  = res_q;
  assign busy      = (state_q != ST_IDLE);
endmodule

// File: rtl/toeplitz_field_hasher.sv
module toeplitz_field_hasher #(
  parameter int NUM_IF   = 2,
  parameter int NUM_SLOT = 2,
  parameter int REG_W    = 64,
  parameter int RES_W    = 32,
  localparam int IF_W    = (NUM_IF > 1) ? $clog2(NUM_IF) : 1,
  localparam int SLOT_W  = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1,
  localparam int OFS_W   = $clog2(fh_pkg::OFS_SLOT_BASE + fh_pkg::SLOT_STRIDE * NUM_SLOT),
  localparam int ADDR_W  = IF_W + OFS_W,
  localparam int DATA_W  = 2 * REG_W,
  localparam int KEY_W   = 2 * REG_W + RES_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IF_W-1:0]   req_if,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [DATA_W-1:0] req_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [RES_W-1:0]  res_hash,
  output logic              busy
);
  logic [REG_W-1:0]  k_a, k_b, m_hi, m_lo, ctl;
  logic [RES_W-1:0]  k_c;
  logic [DATA_W-1:0] masked;
  logic [KEY_W-1:0]  key;

  fh_cfg_regs #(
    .NUM_IF(NUM_IF), .NUM_SLOT(NUM_SLOT), .REG_W(REG_W), .RES_W(RES_W),
    .IF_W(IF_W), .SLOT_W(SLOT_W), .OFS_W(OFS_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .sel_if(req_if), .sel_slot(req_slot),
    .sel_key_a(k_a), .sel_key_b(k_b), .sel_key_c(k_c),
    .sel_mask_hi(m_hi), .sel_mask_lo(m_lo), .sel_ctl(ctl)
  );

  fh_prep #(.REG_W(REG_W), .RES_W(RES_W)) u_prep (
    .field(req_data), .mask_hi(m_hi), .mask_lo(m_lo),
    .key_a(k_a), .key_b(k_b), .key_c(k_c),
    .masked(masked), .key(key)
  );

  fh_serial_core #(.DATA_W(DATA_W), .KEY_W(KEY_W), .RES_W(RES_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready),
    .in_data(masked), .in_key(key), .in_ctl(ctl[2*RES_W-1:0]),
    .out_valid(res_valid), .out_ready(res_ready), .out_hash(res_hash),
    .busy(busy)
  );
endmodule

// File: rtl/fh_sva.sv
module fh_sva #(
  parameter int ADDR_W = 5,
  parameter int OFS_W  = 4,
  parameter int REG_W  = 64,
  parameter int RES_W  = 32,
  parameter int LAT    = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              req_valid,
  input logic              req_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic [RES_W-1:0]  res_hash,
  input logic              busy
);
  localparam int LC_W = $clog2(LAT + 4) + 1;
  logic [LC_W-1:0] lat_cnt;

  // Cycles since the last accepted request, counted while the result is pending
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_cnt <= '0;
    else if (req_valid && req_ready) lat_cnt <= LC_W'(1);
    else if (busy && !res_valid) lat_cnt <= lat_cnt + 1'b1;
  end

  // R9: first valid result appears LAT edges after acceptance
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> (lat_cnt == LC_W'(LAT + 1)));

  // R10: no new request can be taken while a hash is pending
  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R11: result held until the consumer accepts it
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_hash)));

  // R11: handshake returns the block to idle
  p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> (!res_valid && req_ready));

  // R8: capability word always advertises the hash feature
  p_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[OFS_W-1:0] == OFS_W'(fh_pkg::OFS_CAP)) |-> reg_rdata[fh_pkg::CAP_BIT]);
endmodule

bind toeplitz_field_hasher fh_sva #(
  .ADDR_W(ADDR_W), .OFS_W(OFS_W), .REG_W(REG_W), .RES_W(RES_W), .LAT(DATA_W)
) u_sva (.*);

// File: tb/toeplitz_field_hasher_test.sv
module toeplitz_field_hasher_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_we = 1'b0;
  logic [4:0]   reg_addr = '0;
  logic [63:0]  reg_wdata = '0;
  logic [63:0]  reg_rdata;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [0:0]   req_if = '0;
  logic [0:0]   req_slot = '0;
  logic [127:0] req_data = '0;
  logic         res_valid;
  logic         res_ready = 1'b0;
  logic [31:0]  res_hash;
  logic         busy;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int acc_cyc = 0;

  logic [63:0] bk_a [2];
  logic [63:0] bk_b [2];
  logic [31:0] bk_c [2];
  logic [63:0] bmh [2][2];
  logic [63:0] bml [2][2];
  logic [63:0] bct [2][2];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  toeplitz_field_hasher uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_if(req_if),
    .req_slot(req_slot), .req_data(req_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_hash(res_hash),
    .busy(busy)
  );

  function automatic logic [31:0] ref_hash(input logic [127:0] d, input logic [63:0] mh,
      input logic [63:0] ml, input logic [63:0] ka, input logic [63:0] kb,
      input logic [31:0] kc, input logic [63:0] ct);
    logic [158:0] k;
    logic [127:0] x;
    logic [31:0]  a;
    k = {ka, kb, kc[30:0]};
    x = {d[127:64] & mh, d[63:0] & ml};
    a = '0;
    for (int i = 127; i >= 0; i--) begin
      if (x[i]) a = a ^ k[158:127];
      k = k << 1;
    end
    return (a & ct[63:32]) | ct[31:0];
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic wr(input int ifx, input int ofs, input logic [63:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'(ifx * 16 + ofs); reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
    if (ofs == 0) bk_a[ifx] = v;
    if (ofs == 1) bk_b[ifx] = v;
    if (ofs == 2) bk_c[ifx] = v[31:0];
    for (int s = 0; s < 2; s++) begin
      if (ofs == 4 + 4 * s) bmh[ifx][s] = v;
      if (ofs == 5 + 4 * s) bml[ifx][s] = v;
      if (ofs == 6 + 4 * s) bct[ifx][s] = v;
    end
  endtask

  task automatic rd_chk(input int ifx, input int ofs, input logic [63:0] exp, input string rq);
    @(negedge clk);
    reg_addr = 5'(ifx * 16 + ofs);
    #1;
    chk(reg_rdata === exp, rq, $sformatf("read if%0d ofs%0d", ifx, ofs), 128'(reg_rdata), 128'(exp));
  endtask

  task automatic start_req(input int ifx, input int sl, input logic [127:0] d,
                           output logic [31:0] e);
    e = ref_hash(d, bmh[ifx][sl], bml[ifx][sl], bk_a[ifx], bk_b[ifx], bk_c[ifx], bct[ifx][sl]);
    @(negedge clk);
    chk(req_ready === 1'b1, "R10", "ready before request", 128'(req_ready), 128'(1));
    req_valid = 1'b1; req_if = 1'(ifx); req_slot = 1'(sl); req_data = d;
    @(posedge clk);
    #1;
    acc_cyc = cyc;
    req_valid = 1'b0;
  endtask

  task automatic finish_req(input logic [31:0] e, input string rq, input int hold);
    int n;
    n = 0;
    @(negedge clk);
    while (!res_valid && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(cyc - acc_cyc == 128, "R9", "latency", 128'(cyc - acc_cyc), 128'(128));
    chk(res_hash === e, rq, "hash value", 128'(res_hash), 128'(e));
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(res_valid === 1'b1 && res_hash === e, "R11", "held result", 128'(res_hash), 128'(e));
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(res_valid === 1'b0 && req_ready === 1'b1, "R11", "idle after handshake",
        128'({res_valid, req_ready}), 128'(2'b01));
  endtask

  task automatic run(input int ifx, input int sl, input logic [127:0] d, input string rq);
    logic [31:0] e;
    start_req(ifx, sl, d, e);
    finish_req(e, rq, 0);
  endtask

  task automatic run_lit(input int ifx, input int sl, input logic [127:0] d,
                         input logic [31:0] lit, input string rq);
    logic [31:0] e;
    start_req(ifx, sl, d, e);
    chk(e === lit, rq, "bench model vs literal", 128'(e), 128'(lit));
    finish_req(lit, rq, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL R9 watchdog: actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] e, e2;
    void'($urandom(32'd20517));
    for (int i = 0; i < 2; i++) begin
      bk_a[i] = 64'ha9d5af4c9fbc76b1;
      bk_b[i] = 64'ha9d5af4c9fbc87b4;
      bk_c[i] = 32'h5954c9e7;
      for (int s = 0; s < 2; s++) begin
        bmh[i][s] = '1; bml[i][s] = '1; bct[i][s] = 64'hffffffff_00000000;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13: idle state after reset
    chk(req_ready === 1'b1 && res_valid === 1'b0 && busy === 1'b0, "R13", "reset outputs",
        128'({req_ready, res_valid, busy}), 128'(3'b100));

    // R7: reset values of every register
    for (int i = 0; i < 2; i++) begin
      rd_chk(i, 0, 64'ha9d5af4c9fbc76b1, "R7");
      rd_chk(i, 1, 64'ha9d5af4c9fbc87b4, "R7");
      rd_chk(i, 2, 64'h5954c9e7, "R7");
      for (int s = 0; s < 2; s++) begin
        rd_chk(i, 4 + 4 * s, '1, "R7");
        rd_chk(i, 5 + 4 * s, '1, "R7");
        rd_chk(i, 6 + 4 * s, 64'hffffffff_00000000, "R7");
      end
    end

    // R8: capability word, writes to it ignored
    rd_chk(0, 3, 64'h40000000_00000000, "R8");
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'd3; reg_wdata = 64'h0123456789abcdef;
    @(negedge clk);
    reg_we = 1'b0;
    rd_chk(0, 3, 64'h40000000_00000000, "R8");
    rd_chk(1, 3, 64'h40000000_00000000, "R8");

    // R1 R4: only word 0 top bit set gives key bits 158:127
    run_lit(0, 0, {32'h80000000, 96'h0}, 32'ha9d5af4c, "R1");
    // R3: bit 0 alone gives key bits 31:0 = key B bit 0 then key C[30:0]
    run_lit(0, 0, 128'h1, 32'h5954c9e7, "R3");
    // R4: zero data gives zero accumulator
    run_lit(0, 1, 128'h0, 32'h0, "R4");

    // R5: mask then offset on slot 1
    wr(0, 10, 64'h0000ffff_12340000);
    run_lit(0, 1, {32'h80000000, 96'h0}, 32'h1234af4c, "R5");
    run_lit(0, 1, 128'h0, 32'h12340000, "R5");

    // R2: cleared upper mask removes upper half entirely
    wr(0, 4, 64'h0);
    run_lit(0, 0, {64'hfedcba9876543210, 64'h0}, 32'h0, "R2");
    wr(0, 5, 64'h00000000_0000ffff);
    run(0, 0, {64'hffffffffffffffff, 64'h13572468_9abcdef0}, "R2");
    wr(0, 4, '1);
    wr(0, 5, '1);

    // R6: interface 1 key write does not reach interface 0
    wr(1, 0, 64'h11223344_55667788);
    run_lit(1, 0, {32'h80000000, 96'h0}, 32'h11223344, "R6");
    run_lit(0, 0, {32'h80000000, 96'h0}, 32'ha9d5af4c, "R6");

    // R11: back-pressure holds the result
    start_req(0, 0, 128'hdeadbeef_01234567_89abcdef_cafef00d, e);
    finish_req(e, "R11", 6);

    // R10: request while busy is dropped
    start_req(1, 1, 128'h00ff00ff_00ff00ff_12121212_34343434, e);
    repeat (10) @(negedge clk);
    chk(req_ready === 1'b0 && busy === 1'b1, "R10", "busy during hash",
        128'({req_ready, busy}), 128'(2'b01));
    req_valid = 1'b1; req_if = 1'b0; req_slot = 1'b0; req_data = 128'h1;
    @(negedge clk);
    req_valid = 1'b0;
    finish_req(e, "R10", 0);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk(res_valid === 1'b0 && busy === 1'b0, "R10", "no result from dropped request",
          128'({res_valid, busy}), 128'(0));
    end

    // R12: key write during a hash leaves that hash unchanged
    start_req(0, 0, {32'h80000000, 96'h0}, e);
    wr(0, 0, 64'hdeadbeef_00000000);
    wr(0, 6, 64'h0);
    finish_req(32'ha9d5af4c, "R12", 0);
    wr(0, 6, 64'hffffffff_00000000);
    run_lit(0, 0, {32'h80000000, 96'h0}, 32'hdeadbeef, "R12");

    // R4: random keys, masks, control and data
    for (int t = 0; t < 24; t++) begin
      int ifx, sl;
      logic [127:0] d;
      ifx = int'($urandom_range(0, 1));
      sl  = int'($urandom_range(0, 1));
      if (t % 3 == 0) begin
        wr(ifx, 0, {$urandom, $urandom});
        wr(ifx, 1, {$urandom, $urandom});
        wr(ifx, 2, {32'h0, $urandom});
      end
      if (t % 4 == 1) begin
        wr(ifx, 4 + 4 * sl, {$urandom, $urandom});
        wr(ifx, 5 + 4 * sl, {$urandom, $urandom});
      end
      if (t % 5 == 2) wr(ifx, 6 + 4 * sl, {$urandom, $urandom});
      d = {$urandom, $urandom, $urandom, $urandom};
      start_req(ifx, sl, d, e2);
      finish_req(e2, "R4", t % 2);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule